// File: doc/BRIEF.md
# Write-Back L1 Data Cache

This block is a direct-mapped, write-back data cache for a single 32-bit core. On the core side it takes a word address, write data, a 4-bit byte-write mask and a read strobe. It answers each access with a one-cycle ready pulse and, for reads, the addressed word. On the memory side it moves whole 64-byte lines in a single 512-bit transfer. Fills use one request/acknowledge pair and writebacks use another.

The cache holds 256 lines of 64 bytes, or 16 KB in total. An address splits into an 18-bit tag, an 8-bit line index (bits 13:6) and a 6-bit byte offset; bits 5:2 of the offset select the word within the line. Each line carries a valid bit and a dirty bit.

Two whole-cache commands exist. A flush visits every line and writes back each one that is valid and dirty, then marks it clean. A discard invalidates every line and writes nothing back. While either command runs, and during the clearing sweep after reset, the block raises `busy` and accepts no core access.

Top module: `l1_dcache_wb`

## Requirements
- R1: After reset, `busy` stays high for the clearing sweep of all 256 lines (255 cycles after the first edge with reset released). No core access is accepted and no memory request is raised until it drops, and every line is then invalid.
- R2: A read hit returns the addressed word with `cpu_ready` high exactly 3 clock cycles after the edge that accepted the request. A write hit also completes in 3 cycles.
- R3: A read miss raises `mem_rd_req` with `mem_addr` = {tag, index, 6'b0}, installs the returned line and then returns the requested word. Word w of a line occupies bits [32w+31:32w].
- R4: A write hit updates only the bytes whose `cpu_wmask` bit is set; mask bit b covers bits [8b+7:8b] of the word. The line is then marked dirty, with no memory traffic.
- R5: A write miss first fetches the line from memory, then merges the write into it.
- R6: On a miss to a valid dirty line, the old line is written whole to its own address ({old tag, index, 6'b0}) before the new line is fetched. A clean victim is replaced with no writeback.
- R7: A flush writes back every valid dirty line exactly once and leaves those lines valid and clean. A second flush writes nothing, and later accesses to the flushed lines still hit.
- R8: A discard invalidates every line and issues no writeback, so unflushed writes are lost. The next access to a discarded line refetches it from memory.
- R9: `busy` is high while a flush or discard runs, and no `cpu_ready` is given while `busy` is high. A command seen together with a core request in the idle state is served first, and the request completes afterwards.
- R10: `cpu_ready` is a one-cycle pulse. `mem_rd_req` and `mem_wr_req` are never high together. Each request stays high with a stable address until its acknowledge.
- R11: A core request is a read when `cpu_wmask` is zero and `cpu_rd` is high, and a write when `cpu_wmask` is nonzero. The core holds the request until `cpu_ready`. Addresses are word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Core byte address (word-aligned) |
| cpu_wdata | input | 32 | Core write data |
| cpu_wmask | input | 4 | Byte-write mask; nonzero means write |
| cpu_rd | input | 1 | Read strobe, held until ready |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cmd_flush | input | 1 | Start a write-back of all dirty lines |
| cmd_discard | input | 1 | Start an invalidation of all lines |
| busy | output | 1 | High during reset sweep, flush or discard |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Line written back to memory |
| mem_wr_req | output | 1 | Line writeback request |
| mem_wr_ack | input | 1 | Writeback acknowledge |
| mem_rd_req | output | 1 | Line fill request |
| mem_rdata | input | 512 | Fill data, valid with `mem_rd_ack` |
| mem_rd_ack | input | 1 | Fill acknowledge |

## Verification
The embedded assertions watch the handshake rules on every cycle. They check that the ready pulse lasts one cycle, that no ready appears while `busy` is high, that fill and writeback requests never overlap, that each memory request holds its address until acknowledged, and that the store sees at most one write operation per cycle. Latency, byte merging, victim writeback addresses, the exact count of flush writebacks and the loss of data after a discard depend on cache contents. Only the directed scenarios can show those, by comparing against a word-level reference memory and counting memory transfers.

// File: rtl/l1dc_pkg.sv
// Package: shared controller state type for the write-back data cache.
// Assumes: nothing beyond a 4-bit state encoding.
package l1dc_pkg;
    typedef enum logic [3:0] {
        ST_INIT,     // clearing sweep after reset
        ST_IDLE,     // waiting for a command or core access
        ST_LOOKUP,   // tag compare, write-hit merge
        ST_READ,     // pipeline stage toward fixed hit latency
        ST_DONE,     // latch word, pulse ready
        ST_WBACK,    // write dirty victim line
        ST_FILL,     // fetch requested line
        ST_FL_CHK,   // flush walk: inspect line
        ST_FL_WB,    // flush walk: write back dirty line
        ST_DISCARD   // discard walk: invalidate line
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
// Tag, valid and dirty storage for a direct-mapped cache.
// Assumes: the controller issues at most one write operation per cycle;
// valid/dirty are cleared by the controller's sweep rather than by reset.
module dc_tag_store #(
    parameter int NUM_LINES = 256,
    parameter int TAG_W     = 18
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] idx,
    input  logic                         fill_we,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic                         dirty_set,
    input  logic                         dirty_clr,
    input  logic                         inval_we,
    output logic [TAG_W-1:0]             rd_tag,
    output logic                         rd_valid,
    output logic                         rd_dirty
);
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    // Asynchronous read of the addressed entry.
    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    // Apply the single requested update to the addressed entry.
    always_ff @(posedge clk) begin
        if (inval_we) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= 1'b0;
        end else if (fill_we) begin
            tag_q[idx]   <= fill_tag;
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end else if (dirty_clr) begin
            dirty_q[idx] <= 1'b0;
        end
    end

    // R10
    tag_op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inval_we, fill_we, dirty_set, dirty_clr}));
endmodule

// File: rtl/dc_data_store.sv
// Line data storage: whole-line write for fills, masked word write for hits.
// Assumes: line and word writes never occur in the same cycle.
module dc_data_store #(
    parameter int NUM_LINES = 256,
    parameter int LINE_W    = 512,
    parameter int WORD_W    = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [$clog2(NUM_LINES)-1:0]        idx,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]    word_sel,
    input  logic                                line_we,
    input  logic [LINE_W-1:0]                   line_wdata,
    input  logic                                word_we,
    input  logic [WORD_W-1:0]                   word_wdata,
    input  logic [WORD_W/8-1:0]                 word_mask,
    output logic [LINE_W-1:0]                   rd_line,
    output logic [WORD_W-1:0]                   rd_word
);
    localparam int LANES = WORD_W / 8;

    logic [LINE_W-1:0] line_q [NUM_LINES];
    logic [WORD_W-1:0] merged;

    // Read the addressed line and pick out the selected word.
    assign rd_line = line_q[idx];
    assign rd_word = rd_line[word_sel*WORD_W +: WORD_W];

    // Per-lane byte merge of new data over the stored word.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*8 +: 8] = word_mask[l] ? word_wdata[l*8 +: 8] : rd_word[l*8 +: 8];
    end

    // Store a fetched line or a merged word.
    always_ff @(posedge clk) begin
        if (line_we)
            line_q[idx] <= line_wdata;
        else if (word_we)
            line_q[idx][word_sel*WORD_W +: WORD_W] <= merged;
    end

    // R4
    data_op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_we && word_we));
endmodule

// File: rtl/dc_ctrl.sv
// Cache controller: request capture, hit/miss sequencing, victim writeback,
// line fill, and the flush / discard / reset-sweep walks over all lines.
// Assumes: the core holds a request until cpu_ready; memory acknowledges
// each request with a one-cycle pulse while the request is held.
module dc_ctrl
    import l1dc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int LINE_W    = 512,
    parameter int NUM_LINES = 256
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   cpu_addr,
    input  logic [WORD_W-1:0]                   cpu_wdata,
    input  logic [WORD_W/8-1:0]                 cpu_wmask,
    input  logic                                cpu_rd,
    output logic [WORD_W-1:0]                   cpu_rdata,
    output logic                                cpu_ready,
    input  logic                                cmd_flush,
    input  logic                                cmd_discard,
    output logic                                busy,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic                                mem_wr_req,
    input  logic                                mem_wr_ack,
    output logic                                mem_rd_req,
    input  logic                                mem_rd_ack,
    output logic [$clog2(NUM_LINES)-1:0]        arr_idx,
    output logic [$clog2(LINE_W/WORD_W)-1:0]    word_sel,
    input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_W/8)-1:0] tag_rd,
    input  logic                                valid_rd,
    input  logic                                dirty_rd,
    input  logic [WORD_W-1:0]                   word_rd,
    output logic                                fill_we,
    output logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_W/8)-1:0] fill_tag,
    output logic                                dirty_set,
    output logic                                dirty_clr,
    output logic                                inval_we,
    output logic                                line_we,
    output logic                                word_we,
    output logic [WORD_W-1:0]                   word_wdata,
    output logic [WORD_W/8-1:0]                 word_mask
);
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int SEL_W  = $clog2(LINE_W / WORD_W);
    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int LANES  = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    dc_state_e          state_q;
    logic [IDX_W-1:0]   sweep_q;
    logic [TAG_W-1:0]   req_tag_q;
    logic [IDX_W-1:0]   req_idx_q;
    logic [SEL_W-1:0]   req_sel_q;
    logic [WORD_W-1:0]  req_wdata_q;
    logic [LANES-1:0]   req_mask_q;
    logic               req_write_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               ready_q;

    logic sweeping, hit, sweep_last, new_req;

    // Decode walk states, tag match and request presence.
    assign sweeping   = (state_q == ST_INIT) || (state_q == ST_FL_CHK) ||
                        (state_q == ST_FL_WB) || (state_q == ST_DISCARD);
    assign hit        = valid_rd && (tag_rd == req_tag_q);
    assign sweep_last = (sweep_q == LAST_IDX);
    assign new_req    = cpu_rd || (|cpu_wmask);

    assign busy       = sweeping;
    assign cpu_ready  = ready_q;
    assign cpu_rdata  = rdata_q;
    assign arr_idx    = sweeping ? sweep_q : req_idx_q;
    assign word_sel   = req_sel_q;
    assign fill_tag   = req_tag_q;
    assign word_wdata = req_wdata_q;
    assign word_mask  = req_mask_q;

    // Per-state strobes toward the stores and the memory port.
    always_comb begin
        fill_we    = 1'b0;
        dirty_set  = 1'b0;
        dirty_clr  = 1'b0;
        inval_we   = 1'b0;
        line_we    = 1'b0;
        word_we    = 1'b0;
        mem_wr_req = 1'b0;
        mem_rd_req = 1'b0;
        mem_addr   = {req_tag_q, req_idx_q, {OFF_W{1'b0}}};
        case (state_q)
            ST_LOOKUP: begin
                if (hit && req_write_q) begin
                    word_we   = 1'b1;
                    dirty_set = 1'b1;
                end
            end
            ST_WBACK: begin
                mem_wr_req = 1'b1;
                mem_addr   = {tag_rd, req_idx_q, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_ack) begin
                    line_we = 1'b1;
                    fill_we = 1'b1;
                end
            end
            ST_FL_WB: begin
                mem_wr_req = 1'b1;
                mem_addr   = {tag_rd, sweep_q, {OFF_W{1'b0}}};
                dirty_clr  = mem_wr_ack;
            end
            ST_INIT, ST_DISCARD: inval_we = 1'b1;
            default: ;
        endcase
    end

    // State sequencing, request capture, walk counter and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_INIT;
            sweep_q     <= '0;
            req_tag_q   <= '0;
            req_idx_q   <= '0;
            req_sel_q   <= '0;
            req_wdata_q <= '0;
            req_mask_q  <= '0;
            req_write_q <= 1'b0;
            rdata_q     <= '0;
            ready_q     <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    sweep_q <= '0;
                    if (cmd_flush)
                        state_q <= ST_FL_CHK;
                    else if (cmd_discard)
                        state_q <= ST_DISCARD;
                    else if (new_req) begin
                        req_tag_q   <= cpu_addr[ADDR_W-1 -: TAG_W];
                        req_idx_q   <= cpu_addr[OFF_W +: IDX_W];
                        req_sel_q   <= cpu_addr[BOFF_W +: SEL_W];
                        req_wdata_q <= cpu_wdata;
                        req_mask_q  <= cpu_wmask;
                        req_write_q <= |cpu_wmask;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit)
                        state_q <= ST_READ;
                    else if (valid_rd && dirty_rd)
                        state_q <= ST_WBACK;
                    else
                        state_q <= ST_FILL;
                end
                ST_READ:  state_q <= ST_DONE;
                ST_DONE: begin
                    rdata_q <= word_rd;
                    ready_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_WBACK:  if (mem_wr_ack) state_q <= ST_FILL;
                ST_FILL:   if (mem_rd_ack) state_q <= ST_LOOKUP;
                ST_FL_CHK: begin
                    if (valid_rd && dirty_rd)
                        state_q <= ST_FL_WB;
                    else if (sweep_last)
                        state_q <= ST_IDLE;
                    else
                        sweep_q <= sweep_q + 1'b1;
                end
                ST_FL_WB: begin
                    if (mem_wr_ack) begin
                        if (sweep_last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            sweep_q <= sweep_q + 1'b1;
                            state_q <= ST_FL_CHK;
                        end
                    end
                end
                ST_INIT, ST_DISCARD: begin
                    if (sweep_last)
                        state_q <= ST_IDLE;
                    else
                        sweep_q <= sweep_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_ready);
    // R10
    mem_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
    // R10
    wr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_addr)));
    // R10
    rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_addr)));
    // R11
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd || (|cpu_wmask)) |-> (cpu_addr[BOFF_W-1:0] == '0));
endmodule

// File: rtl/l1_dcache_wb.sv
// Top level of the direct-mapped write-back data cache: wires the controller
// to the tag/state store and the line data store, and exposes the core and
// line-wide memory ports.
// Assumes: one outstanding core access; memory returns whole lines.
module l1_dcache_wb #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int LINE_W    = 512,
    parameter int NUM_LINES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [WORD_W-1:0]    cpu_wdata,
    input  logic [WORD_W/8-1:0]  cpu_wmask,
    input  logic                 cpu_rd,
    output logic [WORD_W-1:0]    cpu_rdata,
    output logic                 cpu_ready,
    input  logic                 cmd_flush,
    input  logic                 cmd_discard,
    output logic                 busy,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LINE_W-1:0]    mem_wdata,
    output logic                 mem_wr_req,
    input  logic                 mem_wr_ack,
    output logic                 mem_rd_req,
    input  logic [LINE_W-1:0]    mem_rdata,
    input  logic                 mem_rd_ack
);
    localparam int OFF_W = $clog2(LINE_W / 8);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int SEL_W = $clog2(LINE_W / WORD_W);
    localparam int LANES = WORD_W / 8;

    logic [IDX_W-1:0]  arr_idx;
    logic [SEL_W-1:0]  word_sel;
    logic [TAG_W-1:0]  tag_rd, fill_tag;
    logic              valid_rd, dirty_rd;
    logic [WORD_W-1:0] word_rd, word_wdata;
    logic [LANES-1:0]  word_mask;
    logic              fill_we, dirty_set, dirty_clr, inval_we, line_we, word_we;

    dc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_W(LINE_W), .NUM_LINES(NUM_LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wmask(cpu_wmask),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cmd_flush(cmd_flush), .cmd_discard(cmd_discard), .busy(busy),
        .mem_addr(mem_addr), .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
        .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
        .arr_idx(arr_idx), .word_sel(word_sel),
        .tag_rd(tag_rd), .valid_rd(valid_rd), .dirty_rd(dirty_rd), .word_rd(word_rd),
        .fill_we(fill_we), .fill_tag(fill_tag), .dirty_set(dirty_set),
        .dirty_clr(dirty_clr), .inval_we(inval_we), .line_we(line_we),
        .word_we(word_we), .word_wdata(word_wdata), .word_mask(word_mask)
    );

    dc_tag_store #(
        .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx),
        .fill_we(fill_we), .fill_tag(fill_tag), .dirty_set(dirty_set),
        .dirty_clr(dirty_clr), .inval_we(inval_we),
        .rd_tag(tag_rd), .rd_valid(valid_rd), .rd_dirty(dirty_rd)
    );

    dc_data_store #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx), .word_sel(word_sel),
        .line_we(line_we), .line_wdata(mem_rdata),
        .word_we(word_we), .word_wdata(word_wdata), .word_mask(word_mask),
        .rd_line(mem_wdata), .rd_word(word_rd)
    );
endmodule

// File: tb/l1_dcache_wb_bench.sv
// Directed bench: line-wide memory model, word-level reference image,
// one task per scenario.
module l1_dcache_wb_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_wmask = '0;
    logic         cpu_rd = 1'b0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         cmd_flush = 1'b0;
    logic         cmd_discard = 1'b0;
    logic         busy;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic         mem_wr_req, mem_rd_req;
    logic         mem_wr_ack, mem_rd_ack;
    logic [511:0] mem_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    l1_dcache_wb u_l1_dcache_wb (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wmask(cpu_wmask),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cmd_flush(cmd_flush), .cmd_discard(cmd_discard), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr_req(mem_wr_req),
        .mem_wr_ack(mem_wr_ack), .mem_rd_req(mem_rd_req), .mem_rdata(mem_rdata),
        .mem_rd_ack(mem_rd_ack)
    );

    // Memory image: 4 tags x 32 indices; line slot = {addr[15:14], addr[10:6]}
    logic [511:0] mem_line [128];
    logic [31:0]  ref_w [2048];
    int           n_rd, n_wr;
    logic [31:0]  last_rd_addr, last_wr_addr;
    logic [511:0] last_wr_data;

    function automatic int slot(input logic [31:0] a);
        return {a[15:14], a[10:6]};
    endfunction
    function automatic int widx(input logic [31:0] a);
        return slot(a) * 16 + int'(a[5:2]);
    endfunction
    function automatic logic [31:0] pat(input int l, input int w);
        return 32'hC0DE0000 | (l << 4) | w;
    endfunction
    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return {16'h0, 2'(tag), 3'b000, 5'(idx), 4'(w), 2'b00};
    endfunction

    // Line-wide memory model, acknowledging one cycle after each request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_ack <= 1'b0;
            mem_wr_ack <= 1'b0;
            mem_rdata  <= '0;
            n_rd       <= 0;
            n_wr       <= 0;
            for (int l = 0; l < 128; l++)
                for (int w = 0; w < 16; w++)
                    mem_line[l][w*32 +: 32] <= pat(l, w);
        end else begin
            mem_rd_ack <= mem_rd_req && !mem_rd_ack;
            mem_wr_ack <= mem_wr_req && !mem_wr_ack;
            if (mem_rd_req && !mem_rd_ack) begin
                mem_rdata    <= mem_line[slot(mem_addr)];
                n_rd         <= n_rd + 1;
                last_rd_addr <= mem_addr;
            end
            if (mem_wr_req && !mem_wr_ack) begin
                mem_line[slot(mem_addr)] <= mem_wdata;
                n_wr         <= n_wr + 1;
                last_wr_addr <= mem_addr;
                last_wr_data <= mem_wdata;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One core access; returns data and latency in cycles from acceptance.
    task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] m,
                          output logic [31:0] rd, output int lat);
        int cyc = 0;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = wd; cpu_wmask = m; cpu_rd = (m == 4'b0);
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 2000);
        rd = cpu_rdata;
        lat = cyc - 1;
        cpu_rd = 1'b0; cpu_wmask = '0;
        if (m != 4'b0)
            for (int b = 0; b < 4; b++)
                if (m[b]) ref_w[widx(a)][b*8 +: 8] = wd[b*8 +: 8];
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset_init();
        int cnt = 0;
        bit early = 1'b0;
        int lat = 0;
        logic [31:0] a = mk(0, 1, 2);
        @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = a; cpu_rd = 1'b1;
        check(busy == 1'b1, "R1 busy after reset", 64'(busy), 64'd1);
        @(negedge clk);
        while (busy && cnt < 1000) begin
            if (cpu_ready || mem_rd_req || mem_wr_req) early = 1'b1;
            cnt++;
            @(negedge clk);
        end
        check(cnt == 255, "R1 sweep length", 64'(cnt), 64'd255);
        check(!early, "R1 no accept during sweep", 64'(early), 64'd0);
        while (!cpu_ready && lat < 1000) begin @(negedge clk); lat++; end
        check(cpu_rdata == ref_w[widx(a)], "R3 miss data after init", 64'(cpu_rdata), 64'(ref_w[widx(a)]));
        cpu_rd = 1'b0;
        check(n_rd == 1 && last_rd_addr == {a[31:6], 6'b0}, "R3 fill address",
              64'(last_rd_addr), 64'({a[31:6], 6'b0}));
    endtask

    task automatic t_read_hit();
        logic [31:0] d;
        int lat;
        int r0 = n_rd;
        logic [31:0] a = mk(0, 1, 9);
        access(a, '0, 4'b0, d, lat);
        check(lat == 3, "R2 read hit latency", 64'(lat), 64'd3);
        check(d == ref_w[widx(a)], "R2 read hit data", 64'(d), 64'(ref_w[widx(a)]));
        check(n_rd == r0, "R2 hit no fill", 64'(n_rd), 64'(r0));
    endtask

    task automatic t_write_hit();
        logic [31:0] d;
        int lat;
        int r0 = n_rd, w0 = n_wr;
        logic [31:0] a = mk(0, 1, 3);
        access(a, 32'h11223344, 4'b1010, d, lat);
        check(lat == 3, "R2 write hit latency", 64'(lat), 64'd3);
        access(a, '0, 4'b0, d, lat);
        check(d == ref_w[widx(a)], "R4 byte merge", 64'(d), 64'(ref_w[widx(a)]));
        check(n_rd == r0 && n_wr == w0, "R4 no memory traffic", 64'(n_rd + n_wr), 64'(r0 + w0));
    endtask

    task automatic t_write_miss();
        logic [31:0] d;
        int lat;
        int r0 = n_rd, w0 = n_wr;
        logic [31:0] a = mk(1, 2, 5);
        access(a, 32'hDEADBEEF, 4'b0111, d, lat);
        check(n_rd == r0 + 1 && n_wr == w0, "R5 allocate fetch", 64'(n_rd - r0), 64'd1);
        access(a, '0, 4'b0, d, lat);
        check(d == ref_w[widx(a)], "R5 merged after allocate", 64'(d), 64'(ref_w[widx(a)]));
    endtask

    task automatic t_evict();
        logic [31:0] d;
        int lat;
        int w0 = n_wr;
        logic [31:0] victim = mk(0, 1, 3);
        logic [31:0] a = mk(2, 1, 0);
        access(a, '0, 4'b0, d, lat);
        check(n_wr == w0 + 1, "R6 dirty victim written", 64'(n_wr - w0), 64'd1);
        check(last_wr_addr == {victim[31:6], 6'b0}, "R6 victim address",
              64'(last_wr_addr), 64'({victim[31:6], 6'b0}));
        check(last_wr_data[3*32 +: 32] == ref_w[widx(victim)], "R6 victim data",
              64'(last_wr_data[3*32 +: 32]), 64'(ref_w[widx(victim)]));
        check(d == ref_w[widx(a)], "R3 new line data", 64'(d), 64'(ref_w[widx(a)]));
        w0 = n_wr;
        access(mk(3, 1, 4), '0, 4'b0, d, lat);
        check(n_wr == w0, "R6 clean victim no writeback", 64'(n_wr - w0), 64'd0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        int lat, cnt, w0;
        bit rdy_busy = 1'b0;
        bit ok = 1'b1;
        logic [31:0] lines [3];
        lines[0] = mk(1, 2, 0); lines[1] = mk(3, 1, 0); lines[2] = mk(0, 7, 0);
        access(mk(3, 1, 6), 32'hA1B2C3D4, 4'b1111, d, lat);
        access(mk(0, 7, 1), 32'h0BADF00D, 4'b1100, d, lat);
        w0 = n_wr;
        @(negedge clk);
        cmd_flush = 1'b1; cpu_addr = mk(3, 1, 6); cpu_rd = 1'b1;
        @(negedge clk);
        cmd_flush = 1'b0;
        check(busy == 1'b1, "R9 busy during flush", 64'(busy), 64'd1);
        cnt = 0;
        while (busy && cnt < 5000) begin
            if (cpu_ready) rdy_busy = 1'b1;
            @(negedge clk);
            cnt++;
        end
        check(!rdy_busy, "R9 no ready while busy", 64'(rdy_busy), 64'd0);
        cnt = 0;
        while (!cpu_ready && cnt < 100) begin @(negedge clk); cnt++; end
        cpu_rd = 1'b0;
        check(cpu_rdata == 32'hA1B2C3D4, "R9 held request served after flush", 64'(cpu_rdata), 64'hA1B2C3D4);
        check(n_wr == w0 + 3, "R7 dirty lines written once", 64'(n_wr - w0), 64'd3);
        foreach (lines[i])
            for (int w = 0; w < 16; w++)
                if (mem_line[slot(lines[i])][w*32 +: 32] != ref_w[slot(lines[i])*16 + w]) ok = 1'b0;
        check(ok, "R7 memory matches after flush", 64'(ok), 64'd1);
        w0 = n_wr;
        @(negedge clk); cmd_flush = 1'b1;
        @(negedge clk); cmd_flush = 1'b0;
        wait_idle(cnt);
        check(n_wr == w0, "R7 second flush writes nothing", 64'(n_wr - w0), 64'd0);
        w0 = n_rd;
        access(mk(0, 7, 1), '0, 4'b0, d, lat);
        check(lat == 3 && n_rd == w0, "R7 lines stay valid", 64'(lat), 64'd3);
    endtask

    task automatic t_discard();
        logic [31:0] d;
        int lat, cnt, r0, w0;
        logic [31:0] a = mk(0, 7, 2);
        access(a, 32'h55AA55AA, 4'b1111, d, lat);
        w0 = n_wr;
        @(negedge clk); cmd_discard = 1'b1;
        @(negedge clk); cmd_discard = 1'b0;
        check(busy == 1'b1, "R9 busy during discard", 64'(busy), 64'd1);
        wait_idle(cnt);
        check(n_wr == w0, "R8 discard writes nothing", 64'(n_wr - w0), 64'd0);
        for (int l = 0; l < 128; l++)
            for (int w = 0; w < 16; w++)
                ref_w[l*16 + w] = mem_line[l][w*32 +: 32];
        r0 = n_rd;
        access(a, '0, 4'b0, d, lat);
        check(n_rd == r0 + 1, "R8 refetch after discard", 64'(n_rd - r0), 64'd1);
        check(d == ref_w[widx(a)] && d != 32'h55AA55AA, "R8 unflushed write lost",
              64'(d), 64'(ref_w[widx(a)]));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 128; l++)
            for (int w = 0; w < 16; w++)
                ref_w[l*16 + w] = pat(l, w);
        repeat (3) @(posedge clk);
        t_reset_init();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_evict();
        t_flush();
        t_discard();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule